// File: doc/BRIEF.md
# Rail short-circuit qualifier and shutdown latch

This block decides when a shorted output rail must bring the whole converter down. Every monitored rail supplies a comparator flag that is high while the rail sits below 60% of its programmed target. The block counts millisecond strobes for each rail while that rail's flag stays high. A rail that recovers before its window is full has its count discarded, and operation goes on. A rail whose flag holds through a whole window sets one shared shutdown latch.

The latch, and a per-rail record of which rail tripped it, stays set until both enable inputs are low together. A rail is watched only while its power stage reports it active and past its soft-start ramp, so a rail that is still climbing cannot trip the latch. While the latch is set, every counter is held at zero. The positive rail is index 0 and the negative rail is index 1.

Top module: `scp_latch_ctrl`

## Requirements
- R1: After reset, `shutdown_latched` is 0 and `rail_fault` is all zeros.
- R2: A rail whose `rail_ready` and `under_thr` bits stay high through WINDOW_TICKS (default 10) `tick_ms` strobes sets `shutdown_latched` on the clock edge that samples the last of those strobes. After WINDOW_TICKS-1 strobes the latch is still 0.
- R3: Any cycle in which a monitored rail's `under_thr` is low, or its `rail_ready` is low, clears that rail's count. A later fault then needs a full WINDOW_TICKS strobes again.
- R4: While `rail_ready[i]` is 0, `under_thr[i]` has no effect, however many strobes go by.
- R5: `rail_fault[i]` is set together with the latch when it is rail i that completed its window. Bit 0 is the positive rail and bit 1 the negative rail. If two rails complete their windows in the same cycle, both bits are set.
- R6: Once set, `shutdown_latched` and `rail_fault` hold while at least one of `en_pos` and `en_neg` is high. Driving only one of the enables low does not clear them.
- R7: A clock edge at which `en_pos` and `en_neg` are both low clears `shutdown_latched` and `rail_fault` and clears every count.
- R8: While the latch is set, a rail that completes a further window adds no bit to `rail_fault`.
- R9: Cycles without a `tick_ms` strobe do not advance a count, even if the rail's flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| under_thr | input | NUM_RAILS | Per-rail flag: rail below 60% of target |
| rail_ready | input | NUM_RAILS | Per-rail flag: rail enabled and soft-start finished |
| en_pos | input | 1 | Enable input for the positive rail |
| en_neg | input | 1 | Enable input for the negative rail |
| shutdown_latched | output | 1 | Shared shutdown latch |
| rail_fault | output | NUM_RAILS | Which rail or rails set the latch |

## Verification
For each rail, the bench holds the flag for every strobe count from zero up to two past the window. This shows exactly where the threshold sits, and it shows that the fault is charged to the right rail. A one-cycle dip in the flag just before the window ends shows that the count restarts rather than pauses. A long run of cycles with the flag high and no strobe shows that only strobes are counted. Other patterns are a flagged rail that is not ready, both rails expiring in the same cycle, a second rail expiring after the latch is already set, and releasing the enables one at a time and then together. These show the gating by readiness, the simultaneous fault record, that the fault record freezes once the latch is set, and that the latch clears only when both enables are low.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int unsigned SCP_DEFAULT_RAILS  = 2;
    localparam int unsigned SCP_DEFAULT_WINDOW = 10;

    // Release of the latch needs both enables low together
    function automatic logic scp_release(input logic en_a, input logic en_b);
        return ~en_a & ~en_b;
    endfunction

endpackage

// File: rtl/scp_rail_timer.sv
module scp_rail_timer #(
    parameter int unsigned WINDOW_TICKS = 10,
    localparam int unsigned CNT_W = $clog2(WINDOW_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic under,
    input  logic ready,
    input  logic hold,
    output logic expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_st_t;

    timer_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (hold || !(under && ready)) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == CNT_W'(WINDOW_TICKS - 1)) begin
                expire   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/scp_fault_latch.sv
module scp_fault_latch #(
    parameter int unsigned NUM_RAILS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] expire,
    input  logic                 release_req,
    output logic                 latched,
    output logic [NUM_RAILS-1:0] fault
);

    typedef struct packed {
        logic                 latched;
        logic [NUM_RAILS-1:0] fault;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (release_req) begin
            st_d = '0;
        end else if (!st_q.latched && (|expire)) begin
            st_d.latched = 1'b1;
            st_d.fault   = expire;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latched = st_q.latched;
    assign fault   = st_q.fault;

endmodule

// File: rtl/scp_latch_ctrl.sv
module scp_latch_ctrl
    import scp_pkg::*;
#(
    parameter int unsigned NUM_RAILS    = SCP_DEFAULT_RAILS,
    parameter int unsigned WINDOW_TICKS = SCP_DEFAULT_WINDOW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_ms,
    input  logic [NUM_RAILS-1:0] under_thr,
    input  logic [NUM_RAILS-1:0] rail_ready,
    input  logic                 en_pos,
    input  logic                 en_neg,
    output logic                 shutdown_latched,
    output logic [NUM_RAILS-1:0] rail_fault
);

    logic                 release_req;
    logic                 hold_all;
    logic [NUM_RAILS-1:0] expire;

    assign release_req = scp_release(en_pos, en_neg);
    assign hold_all    = release_req | shutdown_latched;

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        scp_rail_timer #(
            .WINDOW_TICKS(WINDOW_TICKS)
        ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_ms),
            .under (under_thr[g]),
            .ready (rail_ready[g]),
            .hold  (hold_all),
            .expire(expire[g])
        );
    end

    scp_fault_latch #(
        .NUM_RAILS(NUM_RAILS)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .release_req(release_req),
        .latched    (shutdown_latched),
        .fault      (rail_fault)
    );

endmodule

// File: rtl/scp_latch_chk.sv
module scp_latch_chk #(
    parameter int unsigned NUM_RAILS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_ms,
    input logic [NUM_RAILS-1:0] under_thr,
    input logic [NUM_RAILS-1:0] rail_ready,
    input logic                 en_pos,
    input logic                 en_neg,
    input logic                 shutdown_latched,
    input logic [NUM_RAILS-1:0] rail_fault
);

    // R2
    latch_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_latched) |-> $past(tick_ms));

    // R6
    latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_latched && (en_pos || en_neg)) |=> shutdown_latched);

    // R7
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_pos && !en_neg) |=> (!shutdown_latched && rail_fault == '0));

    // R8
    fault_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_latched && (en_pos || en_neg)) |=> $stable(rail_fault));

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail_chk
        // R4
        fault_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rail_fault[g]) |-> $past(rail_ready[g] && under_thr[g]));
    end

endmodule

bind scp_latch_ctrl scp_latch_chk #(
    .NUM_RAILS(NUM_RAILS)
) u_scp_latch_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick_ms         (tick_ms),
    .under_thr       (under_thr),
    .rail_ready      (rail_ready),
    .en_pos          (en_pos),
    .en_neg          (en_neg),
    .shutdown_latched(shutdown_latched),
    .rail_fault      (rail_fault)
);

// File: tb/test_scp_latch_ctrl.sv
module test_scp_latch_ctrl;

    localparam int N = 2;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_ms = 1'b0;
    logic [N-1:0] under_thr = '0;
    logic [N-1:0] rail_ready = '0;
    logic         en_pos = 1'b0;
    logic         en_neg = 1'b0;
    logic         shutdown_latched;
    logic [N-1:0] rail_fault;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    scp_latch_ctrl #(.NUM_RAILS(N), .WINDOW_TICKS(W)) i_scp_latch_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_ms         (tick_ms),
        .under_thr       (under_thr),
        .rail_ready      (rail_ready),
        .en_pos          (en_pos),
        .en_neg          (en_neg),
        .shutdown_latched(shutdown_latched),
        .rail_fault      (rail_fault)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick_ms = 1'b1;
            step();
            tick_ms = 1'b0;
            step();
            step();
        end
    endtask

    task automatic check(input string req, input logic exp_l, input logic [N-1:0] exp_f);
        n_chk++;
        if (shutdown_latched !== exp_l || rail_fault !== exp_f) begin
            n_fail++;
            $display("FAIL %s: latched=%b fault=%b expected latched=%b fault=%b",
                     req, shutdown_latched, rail_fault, exp_l, exp_f);
        end
    endtask

    task automatic release_all();
        under_thr = '0;
        en_pos = 1'b0;
        en_neg = 1'b0;
        step();
        en_pos = 1'b1;
        en_neg = 1'b1;
        step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step();
        rst_n = 1'b1;
        step();
        // R1
        check("R1", 1'b0, '0);

        rail_ready = '1;
        en_pos = 1'b1;
        en_neg = 1'b1;

        // R2 / R5 / R7: sweep strobe counts per rail
        for (int r = 0; r < N; r++) begin
            for (int n = 0; n <= W + 2; n++) begin
                release_all();
                check("R7", 1'b0, '0);
                under_thr = N'(1) << r;
                pulse_ticks(n);
                if (n >= W) check("R5", 1'b1, N'(1) << r);
                else        check("R2", 1'b0, '0);
            end
        end

        // R3: dip one cycle before the last strobe
        release_all();
        under_thr = 2'b01;
        pulse_ticks(W - 1);
        under_thr = 2'b00;
        step();
        under_thr = 2'b01;
        pulse_ticks(W - 1);
        check("R3", 1'b0, '0);
        pulse_ticks(1);
        check("R3", 1'b1, 2'b01);

        // R9: flag held, no strobes
        release_all();
        under_thr = 2'b10;
        for (int k = 0; k < 200; k++) step();
        check("R9", 1'b0, '0);
        pulse_ticks(W);
        check("R9", 1'b1, 2'b10);

        // R4: not ready rail ignored
        release_all();
        rail_ready = 2'b10;
        under_thr = 2'b01;
        pulse_ticks(W + 3);
        check("R4", 1'b0, '0);
        rail_ready = 2'b11;
        pulse_ticks(W - 1);
        check("R4", 1'b0, '0);
        pulse_ticks(1);
        check("R4", 1'b1, 2'b01);

        // R8: second rail after latch set
        under_thr = 2'b11;
        pulse_ticks(W + 2);
        check("R8", 1'b1, 2'b01);

        // R6: single enable low keeps latch
        under_thr = 2'b00;
        en_pos = 1'b0;
        step();
        step();
        check("R6", 1'b1, 2'b01);
        en_pos = 1'b1;
        en_neg = 1'b0;
        step();
        step();
        check("R6", 1'b1, 2'b01);
        en_pos = 1'b0;
        step();
        check("R7", 1'b0, '0);
        en_pos = 1'b1;
        en_neg = 1'b1;
        step();

        // R5: both rails in the same cycle
        under_thr = 2'b11;
        pulse_ticks(W);
        check("R5", 1'b1, 2'b11);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule